// File: doc/BRIEF.md
# Hypercube Dimension-Order Routing Unit

This block makes the next-hop decision at one node of a binary hypercube whose node labels are `DIM`-bit numbers (default 3, eight nodes). Each node has `DIM` neighbours, and each neighbour's label differs from this node's label in exactly one bit. For every message header it accepts, the unit compares the node's own label with the current target. It then picks the link that corrects the lowest differing bit, or it flags the message for local delivery. Because every node corrects bits from least to most significant, all paths follow a fixed dimension order, and the network cannot form a cyclic wait. A path takes at most `DIM` hops, one for each differing bit.

A header carries a final destination, an intermediate node and a phase bit. With spreading enabled, a message injected at this node gets an intermediate node drawn from an internal linear feedback shift register. The message first travels to that node, and from there it travels on to its destination. This scatters hot-spot traffic across the cube. Every decision is held in an output register, so each hop costs one cycle. Both sides use a valid/ready handshake, and the output register stalls under backpressure.

Top module: `hc_router`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Whenever `out_valid` is 0, `in_ready` is 1.
- R2: `out_port` is the index (0 = least significant) of the lowest bit in which `self_addr` and the effective target differ, and `out_deliver` is 0 in that case.
- R3: With phase bit 1 (heading to the destination), the effective target is `in_dst`, and `out_phase` stays 1.
- R4: With phase bit 0 (heading to the intermediate), the effective target is `in_mid`. If `self_addr` equals `in_mid`, the phase becomes 1 and the target becomes `in_dst` in the same decision.
- R5: When the phase is 1 after that update and `self_addr` equals `in_dst`, `out_deliver` is 1 and `out_port` is 0.
- R6: When `in_inject` is 1 and `spread_en` is 1, `out_mid` takes the LFSR value and the phase starts at 0. The LFSR uses next = {s[1:0], s[2]^s[1]} with seed 3'b001, so it runs 001, 010, 101, 011, 111, 110, 100. It advances only on an accepted injection with spreading. When `in_inject` is 1 and `spread_en` is 0, `out_mid` equals `in_dst`, the phase is 1 and the LFSR holds.
- R7: A header accepted at a rising edge (`in_valid` and `in_ready`) appears with `out_valid` = 1 right after that edge. If `out_ready` is 1 and no new header is accepted, `out_valid` drops after the next edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs keep their values.
- R9: Feeding each output header back into the unit with `self_addr` set to the chosen neighbour reaches the destination in dimension order. For example, 010 to 111 passes 010, 011, 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_addr | input | DIM | Label of this node |
| spread_en | input | 1 | Use a random intermediate node for injected messages |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Unit can accept a header |
| in_inject | input | 1 | Header is newly injected at this node |
| in_dst | input | DIM | Final destination |
| in_mid | input | DIM | Intermediate node |
| in_phase | input | 1 | 0 = heading to intermediate, 1 = heading to destination |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Downstream accepts the decision |
| out_port | output | PW | Chosen dimension (link) index |
| out_deliver | output | 1 | Message has arrived at this node |
| out_dst | output | DIM | Destination carried forward |
| out_mid | output | DIM | Intermediate carried forward |
| out_phase | output | 1 | Updated phase bit |

## Verification
The bench builds the unit with its default `DIM` of 3, so the whole eight-node cube is in range. At that size, every link index, a complete three-hop path and the full seven-state LFSR cycle can be reached with short directed sequences. It also covers the intermediate node coinciding with the current node or with the destination, and backpressure holding a decision while a second header waits.

// File: rtl/hc_route_pkg.sv
package hc_route_pkg;

    localparam int HC_DIM = 3;

    typedef enum logic {
        PH_TO_MID = 1'b0,
        PH_TO_DST = 1'b1
    } hc_phase_e;

    // Fibonacci LFSR tap mask for a given width (maximal length)
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            2:       lfsr_taps = 32'h0000_0003;
            3:       lfsr_taps = 32'h0000_0006;
            4:       lfsr_taps = 32'h0000_000C;
            5:       lfsr_taps = 32'h0000_0014;
            6:       lfsr_taps = 32'h0000_0030;
            7:       lfsr_taps = 32'h0000_0060;
            8:       lfsr_taps = 32'h0000_00B8;
            default: lfsr_taps = 32'h0000_0006;
        endcase
    endfunction

endpackage

// File: rtl/hc_lfsr.sv
module hc_lfsr #(
    parameter int W = hc_route_pkg::HC_DIM
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TAPS = W'(hc_route_pkg::lfsr_taps(W));
    localparam logic [W-1:0] SEED = W'(1);

    logic [W-1:0] lfsr_d, lfsr_q;
    logic         fb;

    always_comb begin
        fb     = ^(lfsr_q & TAPS);
        lfsr_d = lfsr_q;
        if (step) begin
            lfsr_d = {lfsr_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign value = lfsr_q;
endmodule

// File: rtl/hc_route_decide.sv
module hc_route_decide #(
    parameter int DIM = hc_route_pkg::HC_DIM,
    parameter int PW  = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic [DIM-1:0] self_addr,
    input  logic           inject,
    input  logic           spread,
    input  logic [DIM-1:0] rand_mid,
    input  logic [DIM-1:0] hdr_dst,
    input  logic [DIM-1:0] hdr_mid,
    input  logic           hdr_phase,
    output logic [DIM-1:0] nxt_dst,
    output logic [DIM-1:0] nxt_mid,
    output logic           nxt_phase,
    output logic [PW-1:0]  nxt_port,
    output logic           nxt_deliver
);
    import hc_route_pkg::*;

    logic [DIM-1:0] mid_eff;
    logic           phase_eff;
    logic [DIM-1:0] target;
    logic [DIM-1:0] diff;

    always_comb begin
        // header as seen after injection handling
        mid_eff   = hdr_mid;
        phase_eff = hdr_phase;
        if (inject) begin
            mid_eff   = spread ? rand_mid : hdr_dst;
            phase_eff = spread ? PH_TO_MID : PH_TO_DST;
        end
        // reaching the intermediate switches to the second leg
        if (phase_eff == PH_TO_MID && self_addr == mid_eff) begin
            phase_eff = PH_TO_DST;
        end
        target = (phase_eff == PH_TO_DST) ? hdr_dst : mid_eff;
        diff   = self_addr ^ target;

        // lowest differing bit wins: scan from the top so the last hit sticks
        nxt_port = '0;
        for (int i = DIM - 1; i >= 0; i--) begin
            if (diff[i]) begin
                nxt_port = PW'(i);
            end
        end
        nxt_deliver = (diff == '0);
        nxt_dst     = hdr_dst;
        nxt_mid     = mid_eff;
        nxt_phase   = phase_eff;
    end
endmodule

// File: rtl/hc_router.sv
module hc_router #(
    parameter int DIM = hc_route_pkg::HC_DIM,
    parameter int PW  = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIM-1:0] self_addr,
    input  logic           spread_en,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic           in_inject,
    input  logic [DIM-1:0] in_dst,
    input  logic [DIM-1:0] in_mid,
    input  logic           in_phase,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [PW-1:0]  out_port,
    output logic           out_deliver,
    output logic [DIM-1:0] out_dst,
    output logic [DIM-1:0] out_mid,
    output logic           out_phase
);
    typedef struct packed {
        logic           valid;
        logic [PW-1:0]  port;
        logic           deliver;
        logic [DIM-1:0] dst;
        logic [DIM-1:0] mid;
        logic           phase;
    } route_st_t;

    route_st_t      st_d, st_q;
    logic [DIM-1:0] rand_mid;
    logic           accept;
    logic           lfsr_step;
    logic [DIM-1:0] dec_dst, dec_mid;
    logic           dec_phase, dec_deliver;
    logic [PW-1:0]  dec_port;

    assign in_ready  = !st_q.valid || out_ready;
    assign accept    = in_valid && in_ready;
    assign lfsr_step = accept && in_inject && spread_en;

    hc_lfsr #(.W(DIM)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lfsr_step),
        .value (rand_mid)
    );

    hc_route_decide #(.DIM(DIM), .PW(PW)) u_decide (
        .self_addr   (self_addr),
        .inject      (in_inject),
        .spread      (spread_en),
        .rand_mid    (rand_mid),
        .hdr_dst     (in_dst),
        .hdr_mid     (in_mid),
        .hdr_phase   (in_phase),
        .nxt_dst     (dec_dst),
        .nxt_mid     (dec_mid),
        .nxt_phase   (dec_phase),
        .nxt_port    (dec_port),
        .nxt_deliver (dec_deliver)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.valid   = 1'b1;
            st_d.port    = dec_port;
            st_d.deliver = dec_deliver;
            st_d.dst     = dec_dst;
            st_d.mid     = dec_mid;
            st_d.phase   = dec_phase;
        end else if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_port    = st_q.port;
    assign out_deliver = st_q.deliver;
    assign out_dst     = st_q.dst;
    assign out_mid     = st_q.mid;
    assign out_phase   = st_q.phase;
endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk #(
    parameter int DIM = hc_route_pkg::HC_DIM,
    parameter int PW  = (DIM > 1) ? $clog2(DIM) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [PW-1:0]  out_port,
    input logic           out_deliver,
    input logic [DIM-1:0] out_dst,
    input logic           out_phase
);
    // R1
    idle_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port)
            && $stable(out_dst) && $stable(out_deliver) && $stable(out_phase)));

    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R5
    deliver_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_deliver) |-> (out_phase && out_port == '0));

    // R2
    port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_port) < DIM));
endmodule

bind hc_router hc_router_chk #(.DIM(DIM), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_port    (out_port),
    .out_deliver (out_deliver),
    .out_dst     (out_dst),
    .out_phase   (out_phase)
);

// File: tb/hc_router_test.sv
module hc_router_test;
    localparam int DIM = 3;
    localparam int PW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DIM-1:0] self_addr = '0;
    logic           spread_en = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic           in_inject = 1'b0;
    logic [DIM-1:0] in_dst = '0;
    logic [DIM-1:0] in_mid = '0;
    logic           in_phase = 1'b1;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [PW-1:0]  out_port;
    logic           out_deliver;
    logic [DIM-1:0] out_dst;
    logic [DIM-1:0] out_mid;
    logic           out_phase;

    int n_vec  = 0;
    int n_miss = 0;

    always #2 clk = ~clk;

    hc_router #(.DIM(DIM), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .self_addr(self_addr), .spread_en(spread_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_inject(in_inject),
        .in_dst(in_dst), .in_mid(in_mid), .in_phase(in_phase),
        .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
        .out_deliver(out_deliver), .out_dst(out_dst), .out_mid(out_mid),
        .out_phase(out_phase)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one header at the falling edge, sample just after the next rising edge
    task automatic send(input logic [2:0] self, input logic inj, input logic spr,
                        input logic [2:0] dst, input logic [2:0] mid, input logic ph);
        @(negedge clk);
        self_addr = self; in_inject = inj; spread_en = spr;
        in_dst = dst; in_mid = mid; in_phase = ph; in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0; in_inject = 1'b0;
    endtask

    task automatic expect_route(input string req, input int port, input int dlv,
                                input int ph, input int mid);
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "out_port", int'(out_port), port);
        check(req, "out_deliver", int'(out_deliver), dlv);
        check(req, "out_phase", int'(out_phase), ph);
        if (mid >= 0) check(req, "out_mid", int'(out_mid), mid);
    endtask

    task automatic t_reset;
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_direct;
        send(3'b000, 0, 0, 3'b100, 3'b000, 1); expect_route("R2", 2, 0, 1, -1);
        send(3'b101, 0, 0, 3'b001, 3'b000, 1); expect_route("R2", 2, 0, 1, -1);
        send(3'b110, 0, 0, 3'b000, 3'b000, 1); expect_route("R3", 1, 0, 1, -1);
        send(3'b111, 0, 0, 3'b110, 3'b011, 1); expect_route("R3", 0, 0, 1, -1);
    endtask

    task automatic t_path;
        logic [2:0] node;
        logic [2:0] seen [3];
        node = 3'b010;
        for (int h = 0; h < 3; h++) begin
            seen[h] = node;
            send(node, 0, 0, 3'b111, 3'b000, 1);
            if (out_deliver) break;
            node = node ^ (3'b001 << out_port);
        end
        check("R9", "hop0", int'(seen[0]), 2);
        check("R9", "hop1", int'(seen[1]), 3);
        check("R9", "hop2", int'(seen[2]), 7);
        check("R9", "arrived", int'(out_deliver), 1);
    endtask

    task automatic t_two_phase;
        send(3'b000, 0, 0, 3'b011, 3'b101, 0); expect_route("R4", 0, 0, 0, 5);
        send(3'b101, 0, 0, 3'b011, 3'b101, 0); expect_route("R4", 1, 0, 1, 5);
        send(3'b100, 0, 0, 3'b100, 3'b100, 0); expect_route("R5", 0, 1, 1, 4);
        send(3'b110, 0, 0, 3'b110, 3'b001, 1); expect_route("R5", 0, 1, 1, -1);
        check("R5", "out_dst", int'(out_dst), 6);
    endtask

    task automatic t_inject;
        send(3'b000, 1, 1, 3'b111, 3'b000, 1); expect_route("R6", 0, 0, 0, 1);
        send(3'b000, 1, 1, 3'b111, 3'b000, 1); expect_route("R6", 1, 0, 0, 2);
        send(3'b000, 1, 1, 3'b111, 3'b000, 0); expect_route("R6", 0, 0, 0, 5);
        send(3'b001, 1, 0, 3'b100, 3'b010, 0); expect_route("R6", 0, 0, 1, 4);
        // non-spread injection left the LFSR at 011; self equals it so phase flips
        send(3'b011, 1, 1, 3'b001, 3'b000, 1); expect_route("R6", 1, 0, 1, 3);
    endtask

    task automatic t_backpressure;
        @(negedge clk); out_ready = 1'b0;
        send(3'b000, 0, 0, 3'b010, 3'b000, 1); expect_route("R8", 1, 0, 1, -1);
        @(negedge clk);
        self_addr = 3'b000; in_dst = 3'b100; in_phase = 1'b1; in_valid = 1'b1;
        #1;
        check("R8", "in_ready while stalled", int'(in_ready), 0);
        @(posedge clk); #1;
        check("R8", "held port", int'(out_port), 1);
        check("R8", "held dst", int'(out_dst), 2);
        check("R8", "held valid", int'(out_valid), 1);
        @(negedge clk); out_ready = 1'b1;
        @(posedge clk); #1;
        check("R8", "second accepted port", int'(out_port), 2);
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check("R7", "valid drops when drained", int'(out_valid), 0);
        check("R1", "in_ready when idle", int'(in_ready), 1);
    endtask

    task automatic t_latency;
        @(negedge clk);
        self_addr = 3'b001; in_dst = 3'b000; in_phase = 1'b1; in_valid = 1'b1;
        #1;
        check("R7", "no output before edge", int'(out_valid), 0);
        @(posedge clk); #1;
        check("R7", "output right after edge", int'(out_valid), 1);
        check("R7", "port", int'(out_port), 0);
        @(negedge clk); in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_path();
        t_two_phase();
        t_inject();
        t_backpressure();
        t_latency();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #40000;
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule